// File: doc/BRIEF.md
# Interrupted-Burst Write Mask Generator

This block sits in the write datapath of a double-data-rate memory controller. It produces, for each clock, the byte masks of the two data beats carried in that clock: one beat on the rising strobe edge and one on the falling edge. It also produces the strobe output-enable and a running count of the beats of the current burst that were not force-masked. A write command starts a burst with a length of 2, 4, 8 or 16 beats. A later write may cut that burst off, and the new data then follows directly behind the last beat that was kept. A precharge command to the same bank may also cut the burst. In that case the leftover beats are still transferred and strobed, but with every mask bit set, so the memory records the mask state and stores none of that data.

The user byte mask supplied with each beat is ORed with the forced mask. When no beat is being transferred, the strobe enable is low except in the one-cycle preamble before a burst and the one-cycle postamble after it. Outside those windows the strobe is in its high-impedance state.

Top module: `ddr_wr_mask_gen`

## Requirements
- R1: After reset, and with no commands, dqs_oe and beat_act are 0, both mask outputs are all ones and valid_beats is 0.
- R2: A write command sampled at clock edge k, with wr_bl code c, gives 2^c beat cycles of two beats each (code 0 = 2 beats, 1 = 4, 2 = 8, 3 = 16). These beat cycles directly follow edges k+1 to k+2^c. If the cycle after edge k carries no beat of an older burst, it is a preamble cycle: dqs_oe 1, beat_act 0.
- R3: In every beat cycle of a burst that has not been cut, dm_rise equals um_rise and dm_fall equals um_fall in that same cycle.
- R4: After the last beat cycle of a burst that no further write follows, there is exactly one postamble cycle (dqs_oe 1, beat_act 0), and then dqs_oe is 0.
- R5: A precharge sampled at the edge that ends a beat cycle, when that burst still has beat cycles left, forces both masks to all ones in every later beat cycle of that burst. beat_act and dqs_oe stay 1 until the burst's nominal end.
- R6: valid_beats is 0 during the first beat cycle of a burst. It rises by 2 after each beat cycle that is not force-masked, holds after a precharge cut, and holds between bursts.
- R7: A write sampled at the edge that ends a beat cycle of an older burst still lets the older burst send one more beat cycle if it has one left. The rest of the older burst is dropped, and the new burst's beats start in the very next cycle, with no preamble or postamble between them.
- R8: A precharge sampled when no later beat cycle of the current burst remains has no effect. This covers idle, preamble, postamble and the final beat cycle.
- R9: In every cycle with beat_act 0, both masks are all ones.
- R10: A burst that starts after a cut burst is not masked, and only the user mask applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | Write command strobe |
| wr_bl | input | BL_W | Burst length code, beats = 2 << code |
| pre_cmd | input | 1 | Precharge command to the bank being written |
| um_rise | input | BYTES | User byte mask for the rising-edge beat of this cycle |
| um_fall | input | BYTES | User byte mask for the falling-edge beat of this cycle |
| dm_rise | output | BYTES | Byte mask driven with the rising-edge beat |
| dm_fall | output | BYTES | Byte mask driven with the falling-edge beat |
| dqs_oe | output | 1 | Strobe drive enable (preamble, beats, postamble) |
| beat_act | output | 1 | This cycle carries two data beats |
| valid_beats | output | CNT_W | Unmasked beats of the current burst already transferred |

## Verification
The bench targets the following corner cases, and the stimulus also mixes all of them randomly:
- A precharge that lands on the last beat cycle of a burst. A design that checks the wrong boundary masks the first beats of the next burst or leaves nothing masked.
- A write issued exactly one beat cycle before a burst ends. A wrong design inserts a spurious preamble or postamble and breaks the continuous strobe.
- A write issued in a postamble. This must turn that cycle into a preamble.
- A write that follows a cut burst. A cut flag that is never cleared would go on masking every later burst.
- A precharge and a write in the same cycle.

In each case the reference model catches a mistimed counter reset or a missing hold of the count as a wrong valid_beats.

// File: rtl/ddr_wr_mask_gen.sv
module ddr_wr_mask_gen #(
  parameter int BYTES = 4,
  parameter int BL_W  = 2,
  localparam int MAX_PAIRS = 1 << ((1 << BL_W) - 1),
  localparam int REM_W = $clog2(MAX_PAIRS + 1),
  localparam int CNT_W = $clog2(2 * MAX_PAIRS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [BL_W-1:0]  wr_bl,
  input  logic             pre_cmd,
  input  logic [BYTES-1:0] um_rise,
  input  logic [BYTES-1:0] um_fall,
  output logic [BYTES-1:0] dm_rise,
  output logic [BYTES-1:0] dm_fall,
  output logic             dqs_oe,
  output logic             beat_act,
  output logic [CNT_W-1:0] valid_beats
);

  logic [REM_W-1:0] rem, plen;
  logic [CNT_W-1:0] cnt;
  logic             pend, post, cut;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      plen <= '0;
      cnt  <= '0;
      pend <= 1'b0;
      post <= 1'b0;
      cut  <= 1'b0;
    end else begin
      if (pend) begin
        rem <= plen;
        cut <= 1'b0;
        cnt <= '0;
      end else begin
        if (rem != '0) rem <= rem - 1'b1;
        if (rem != '0 && !cut) cnt <= cnt + CNT_W'(2);
        if (pre_cmd && rem > REM_W'(1)) cut <= 1'b1;
      end
      pend <= wr_cmd;
      if (wr_cmd) plen <= REM_W'(1) << wr_bl;
      post <= (rem == REM_W'(1)) && !pend;
    end
  end

  assign beat_act    = (rem != '0);
  assign dqs_oe      = beat_act | pend | post;
  assign dm_rise     = (!beat_act || cut) ? '1 : um_rise;
  assign dm_fall     = (!beat_act || cut) ? '1 : um_fall;
  assign valid_beats = cnt;

endmodule

module ddr_wr_mask_gen_chk #(
  parameter int BYTES = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_cmd,
  input logic             pre_cmd,
  input logic [BYTES-1:0] dm_rise,
  input logic [BYTES-1:0] dm_fall,
  input logic             dqs_oe,
  input logic             beat_act,
  input logic [CNT_W-1:0] valid_beats
);

  assert_beats_strobed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_act |-> dqs_oe);

  assert_preamble_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe) |-> !beat_act);

  assert_postamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(beat_act) |-> dqs_oe);

  assert_cut_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_act && $past(beat_act) && $past(pre_cmd) && !$past(wr_cmd, 2))
      |-> (dm_rise == '1 && dm_fall == '1));

  assert_count_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_beats[0] == 1'b0);

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_act && $past(!beat_act)) |-> $stable(valid_beats));

  assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dqs_oe && !wr_cmd) |=> !dqs_oe);

  assert_idle_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_act |-> (dm_rise == '1 && dm_fall == '1));

endmodule

bind ddr_wr_mask_gen ddr_wr_mask_gen_chk #(.BYTES(BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .pre_cmd(pre_cmd),
  .dm_rise(dm_rise), .dm_fall(dm_fall), .dqs_oe(dqs_oe),
  .beat_act(beat_act), .valid_beats(valid_beats)
);

// File: tb/ddr_wr_mask_gen_tb.sv
`timescale 1ns/1ps
module ddr_wr_mask_gen_tb;
  localparam int BYTES = 4;
  localparam int BL_W  = 2;
  localparam int CNT_W = 5;
  localparam int IDLE = 0, PRE = 1, BEAT = 2, POST = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_cmd = 1'b0, pre_cmd = 1'b0;
  logic [BL_W-1:0] wr_bl = '0;
  logic [BYTES-1:0] um_rise = '0, um_fall = '0;
  logic [BYTES-1:0] dm_rise, dm_fall;
  logic dqs_oe, beat_act;
  logic [CNT_W-1:0] valid_beats;

  always #2.5 clk = ~clk;

  ddr_wr_mask_gen #(.BYTES(BYTES), .BL_W(BL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_bl(wr_bl), .pre_cmd(pre_cmd),
    .um_rise(um_rise), .um_fall(um_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
    .dqs_oe(dqs_oe), .beat_act(beat_act), .valid_beats(valid_beats)
  );

  typedef struct { int kind; int id; } ent_t;
  ent_t q[$];
  bit cut_of[int];
  int nid = 1, last_id = 0, disp = 0;
  int vectors = 0, fails = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit w, input logic [BL_W-1:0] bl, input bit p);
    int kind, id;
    bit cutc, more;
    logic [BYTES-1:0] er, ef;
    ent_t e;
    @(negedge clk);
    wr_cmd = w; wr_bl = bl; pre_cmd = p;
    um_rise = BYTES'($urandom); um_fall = BYTES'($urandom);
    #1;
    kind = IDLE; id = 0;
    if (q.size() > 0) begin kind = q[0].kind; id = q[0].id; end
    cutc = (kind == BEAT) && cut_of.exists(id) && cut_of[id];
    if (kind == BEAT && id != last_id) begin disp = 0; last_id = id; end
    er = (kind == BEAT && !cutc) ? um_rise : '1;
    ef = (kind == BEAT && !cutc) ? um_fall : '1;
    check(beat_act == (kind == BEAT), kind == POST ? "R4" : "R2", beat_act, kind == BEAT);
    check(dqs_oe == (kind != IDLE), kind == IDLE ? "R8" : (kind == POST ? "R4" : "R7"),
          dqs_oe, kind != IDLE);
    check(dm_rise == er && dm_fall == ef,
          kind != BEAT ? "R9" : (cutc ? "R5" : "R3"), {dm_rise, dm_fall}, {er, ef});
    check(valid_beats == CNT_W'(disp), "R6", valid_beats, disp);
    // advance the model past the edge that ends this cycle
    if (q.size() > 0) void'(q.pop_front());
    if (kind == BEAT && !cutc) disp += 2;
    if (p && kind == BEAT) begin
      more = 0;
      foreach (q[i]) if (q[i].kind == BEAT && q[i].id == id) more = 1;
      if (more) cut_of[id] = 1;
    end
    if (w) begin
      if (q.size() > 0 && q[0].kind == BEAT) begin
        e = q[0]; q.delete(); q.push_back(e);
      end else begin
        q.delete(); e.kind = PRE; e.id = 0; q.push_back(e);
      end
      for (int i = 0; i < (1 << bl); i++) begin e.kind = BEAT; e.id = nid; q.push_back(e); end
      e.kind = POST; e.id = nid; q.push_back(e);
      nid++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!dqs_oe && !beat_act && dm_rise == '1 && dm_fall == '1 && valid_beats == '0,
          "R1", {dqs_oe, beat_act, valid_beats}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);                                   // R1 idle after reset
    cyc(1, 2'd2, 0); idle(12);                 // R2 R3 R4 eight beats
    cyc(1, 2'd0, 0); idle(5);                  // R2 shortest
    cyc(1, 2'd3, 0); idle(14);                 // R2 longest
    cyc(1, 2'd2, 0); idle(2); cyc(0, '0, 1); idle(8);  // R5 cut mid-burst
    cyc(1, 2'd1, 0); idle(6);                  // R10 clean burst after cut
    cyc(0, '0, 1); idle(2);                    // R8 precharge idle
    cyc(1, 2'd1, 0); cyc(0, '0, 1); idle(1); cyc(0, '0, 1); idle(4); // R8 preamble, last beat
    cyc(1, 2'd2, 0); idle(2); cyc(1, 2'd1, 0); idle(8);  // R7 truncating write
    cyc(1, 2'd1, 0); idle(1); cyc(1, 2'd1, 0); idle(7);  // R7 seamless
    cyc(1, 2'd0, 0); idle(1); cyc(1, 2'd0, 0); idle(5);  // write in final beat / postamble
    cyc(1, 2'd2, 0); idle(1); cyc(1, 2'd0, 1); idle(6);  // precharge with write
    cyc(1, 2'd2, 0); idle(2); cyc(0, '0, 1); cyc(1, 2'd1, 0); idle(8); // R10 write after cut
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 6) == 0, BL_W'($urandom), ($urandom % 7) == 0);
    idle(20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule